// File: doc/BRIEF.md
# Flash Erase and Program Sequencer

This block is a host-side controller for a byte-wide command-driven flash device. On a program request it first erases the whole device one block at a time, then writes every byte from a source data port, lowest address first. After each erase confirm and after each programmed byte it asks the device for status, reads until the device reports ready, and returns the device to array mode. It checks the captured status for error bits before it moves on.

A second request type runs an identifier probe. The block reads the two identifier bytes and compares them against expected values supplied on input ports. Each run ends with a one-cycle completion pulse. The error flag, the timeout flag, the failing address and the probe verdict stay valid until the next accepted request.

The device has 2^ADDR_W bytes and erase blocks of 2^BLK_W bytes. Every bus cycle is a single-cycle write strobe or a single-cycle read strobe. Read data is sampled at the clock edge that ends the read cycle.

Top module: `flash_erase_prog_seq`

## Requirements
- R1: After reset `busy`, `done`, `err`, `err_tmo`, `bus_we` and `bus_re` are all 0. No bus strobe is ever driven while `busy` is 0.
- R2: For each block, in ascending order, the block writes 0x50, then 0x20, then 0xD0, all to the block base address. The block size is 2^BLK_W bytes.
- R3: Every wait writes 0x70 to address 0, then reads address 0 until bit 7 of the read data is 1, then writes 0xFF to address 0. There is exactly one such 0xFF per wait, and this holds even when the wait ends in an error.
- R4: No program command (0x40) is issued until every block has had its 0xD0 confirm and its wait.
- R5: Each byte is programmed in ascending address order as 0x40 then the data byte, both written to the target address. The data comes from `src_data` while `src_addr` equals the target address. A wait follows each byte.
- R6: If a captured status byte has any of bits 5, 4, 3 or 1 set, the run stops after that wait's 0xFF. `err` goes to 1 together with `done`, and `err_addr` holds the block base address (erase) or the byte address (program).
- R7: If POLL_MAX consecutive status reads all show bit 7 = 0, the block stops polling. It still writes 0xFF and then ends with `err` = 1, `err_tmo` = 1 and `err_addr` set to the address being worked on.
- R8: A probe writes 0xFF, then 0x90, reads address 0, reads address 1, then writes 0xFF. `probe_match` is 1 only when the first read equals `exp_id0` and the second equals `exp_id1`.
- R9: `done` is a single-cycle pulse. `busy` stays 1 from the cycle after a request is accepted until the cycle in which `done` is 1.
- R10: Requests are accepted only while idle; a request raised while `busy` is 1 has no effect. If both requests arrive in the same idle cycle, the program request is taken and the probe request is dropped.
- R11: `bus_we` and `bus_re` are never 1 in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_prog | input | 1 | Request: erase the whole device, then program it |
| start_probe | input | 1 | Request: identifier probe |
| exp_id0 | input | 8 | Expected identifier byte at offset 0 |
| exp_id1 | input | 8 | Expected identifier byte at offset 1 |
| src_addr | output | ADDR_W | Address of the source byte being requested |
| src_data | input | 8 | Source byte for `src_addr` |
| bus_addr | output | ADDR_W | Device bus address |
| bus_wdata | output | 8 | Device bus write data |
| bus_we | output | 1 | Device write strobe |
| bus_re | output | 1 | Device read strobe |
| bus_rdata | input | 8 | Device read data, sampled at the end of a read cycle |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | The last run stopped on an error |
| err_tmo | output | 1 | The error was a ready-poll timeout |
| err_addr | output | ADDR_W | Address at which the error occurred |
| probe_match | output | 1 | Both identifier bytes matched on the last probe |

## Verification
The two requests can land in the same idle cycle. The bench drives both strobes in one cycle and then confirms, from a bus monitor, that a full erase and program ran and that no 0x90 write appeared. The probe request can also arrive while a program run is in progress. The bench pulses it halfway through a run and judges the result by the absence of identifier commands and by exactly one completion pulse. A status error and the final status reset also share a wait: injected program and erase failures and a stuck-busy device must each still produce the closing 0xFF and report the right address.

// File: rtl/fseq_pkg.sv
package fseq_pkg;
    localparam int DW = 8;

    localparam logic [DW-1:0] CMD_CLR_STAT = 8'h50;
    localparam logic [DW-1:0] CMD_ERASE    = 8'h20;
    localparam logic [DW-1:0] CMD_CONFIRM  = 8'hD0;
    localparam logic [DW-1:0] CMD_STATUS   = 8'h70;
    localparam logic [DW-1:0] CMD_ARRAY    = 8'hFF;
    localparam logic [DW-1:0] CMD_PROGRAM  = 8'h40;
    localparam logic [DW-1:0] CMD_IDENT    = 8'h90;

    localparam int              STAT_READY_BIT = 7;
    localparam logic [DW-1:0]   STAT_ERR_MASK  = 8'h3A; // bits 5,4,3,1

    typedef enum logic [3:0] {
        S_IDLE, S_E_CLR, S_E_CMD, S_E_CONF,
        S_W_CMD, S_W_POLL, S_W_RST,
        S_P_CMD, S_P_DATA,
        S_I_RST0, S_I_ENTER, S_I_RD0, S_I_RD1, S_I_RST1,
        S_FIN
    } seq_state_t;

    function automatic logic stat_failed(input logic [DW-1:0] s);
        return |(s & STAT_ERR_MASK);
    endfunction
endpackage

// File: rtl/fseq_addr_gen.sv
module fseq_addr_gen #(
    parameter int ADDR_W = 6,
    parameter int BLK_W  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              step_blk,
    input  logic              step_byte,
    output logic [ADDR_W-1:0] addr,
    output logic              last_blk,
    output logic              last_byte
);
    localparam logic [ADDR_W-1:0] BLK_STEP = ADDR_W'(1 << BLK_W);

    always_ff @(posedge clk) begin
        if (rst || clr)     addr <= '0;
        else if (step_blk)  addr <= addr + BLK_STEP;
        else if (step_byte) addr <= addr + 1'b1;
    end

    assign last_blk  = &addr[ADDR_W-1:BLK_W];
    assign last_byte = &addr;
endmodule

// File: rtl/fseq_poll_timer.sv
module fseq_poll_timer #(
    parameter int POLL_MAX = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic tick,
    output logic expired
);
    localparam int              CW   = $clog2(POLL_MAX + 1);
    localparam logic [CW-1:0]   LAST = CW'(POLL_MAX - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || clr) cnt <= '0;
        else if (tick)  cnt <= cnt + 1'b1;
    end

    assign expired = tick && (cnt == LAST);
endmodule

// File: rtl/fseq_status_eval.sv
module fseq_status_eval
    import fseq_pkg::*;
(
    input  logic [DW-1:0] stat,
    output logic          ready,
    output logic          fail
);
    assign ready = stat[STAT_READY_BIT];
    assign fail  = stat_failed(stat);
endmodule

// File: rtl/flash_erase_prog_seq.sv
module flash_erase_prog_seq
    import fseq_pkg::*;
#(
    parameter int ADDR_W   = 6,
    parameter int BLK_W    = 4,
    parameter int POLL_MAX = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_prog,
    input  logic              start_probe,
    input  logic [7:0]        exp_id0,
    input  logic [7:0]        exp_id1,
    output logic [ADDR_W-1:0] src_addr,
    input  logic [7:0]        src_data,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [7:0]        bus_wdata,
    output logic              bus_we,
    output logic              bus_re,
    input  logic [7:0]        bus_rdata,
    output logic              busy,
    output logic              done,
    output logic              err,
    output logic              err_tmo,
    output logic [ADDR_W-1:0] err_addr,
    output logic              probe_match
);
    seq_state_t        state, nxt;
    logic [ADDR_W-1:0] cur;
    logic              last_blk, last_byte;
    logic              ag_clr, ag_blk, ag_byte;
    logic              tm_clr, tm_tick, tm_expired;
    logic              st_ready, st_fail;
    logic              prog_phase, fail_q, tmo_q, id0_ok;

    fseq_addr_gen #(.ADDR_W(ADDR_W), .BLK_W(BLK_W)) u_addr (
        .clk(clk), .rst(rst), .clr(ag_clr), .step_blk(ag_blk), .step_byte(ag_byte),
        .addr(cur), .last_blk(last_blk), .last_byte(last_byte)
    );

    fseq_poll_timer #(.POLL_MAX(POLL_MAX)) u_timer (
        .clk(clk), .rst(rst), .clr(tm_clr), .tick(tm_tick), .expired(tm_expired)
    );

    fseq_status_eval u_stat (.stat(bus_rdata), .ready(st_ready), .fail(st_fail));

    // next state and sub-block control
    always_comb begin
        nxt     = state;
        ag_clr  = 1'b0;
        ag_blk  = 1'b0;
        ag_byte = 1'b0;
        tm_clr  = 1'b0;
        tm_tick = 1'b0;
        case (state)
            S_IDLE: begin
                if (start_prog) begin
                    nxt    = S_E_CLR;
                    ag_clr = 1'b1;
                end else if (start_probe) begin
                    nxt = S_I_RST0;
                end
            end
            S_E_CLR:  nxt = S_E_CMD;
            S_E_CMD:  nxt = S_E_CONF;
            S_E_CONF: nxt = S_W_CMD;
            S_P_CMD:  nxt = S_P_DATA;
            S_P_DATA: nxt = S_W_CMD;
            S_W_CMD: begin
                nxt    = S_W_POLL;
                tm_clr = 1'b1;
            end
            S_W_POLL: begin
                tm_tick = 1'b1;
                if (st_ready || tm_expired) nxt = S_W_RST;
            end
            S_W_RST: begin
                if (fail_q || tmo_q) begin
                    nxt = S_FIN;
                end else if (!prog_phase) begin
                    if (last_blk) begin
                        nxt    = S_P_CMD;
                        ag_clr = 1'b1;
                    end else begin
                        nxt    = S_E_CLR;
                        ag_blk = 1'b1;
                    end
                end else if (last_byte) begin
                    nxt = S_FIN;
                end else begin
                    nxt     = S_P_CMD;
                    ag_byte = 1'b1;
                end
            end
            S_I_RST0:  nxt = S_I_ENTER;
            S_I_ENTER: nxt = S_I_RD0;
            S_I_RD0:   nxt = S_I_RD1;
            S_I_RD1:   nxt = S_I_RST1;
            S_I_RST1:  nxt = S_FIN;
            S_FIN:     nxt = S_IDLE;
            default:   nxt = S_IDLE;
        endcase
    end

    // bus cycle for the current state
    always_comb begin
        bus_we    = 1'b0;
        bus_re    = 1'b0;
        bus_addr  = '0;
        bus_wdata = CMD_ARRAY;
        case (state)
            S_E_CLR:   begin bus_we = 1'b1; bus_addr = cur; bus_wdata = CMD_CLR_STAT; end
            S_E_CMD:   begin bus_we = 1'b1; bus_addr = cur; bus_wdata = CMD_ERASE;    end
            S_E_CONF:  begin bus_we = 1'b1; bus_addr = cur; bus_wdata = CMD_CONFIRM;  end
            S_P_CMD:   begin bus_we = 1'b1; bus_addr = cur; bus_wdata = CMD_PROGRAM;  end
            S_P_DATA:  begin bus_we = 1'b1; bus_addr = cur; bus_wdata = src_data;     end
            S_W_CMD:   begin bus_we = 1'b1; bus_wdata = CMD_STATUS; end
            S_W_POLL:  bus_re = 1'b1;
            S_W_RST:   bus_we = 1'b1;
            S_I_RST0:  bus_we = 1'b1;
            S_I_ENTER: begin bus_we = 1'b1; bus_wdata = CMD_IDENT; end
            S_I_RD0:   bus_re = 1'b1;
            S_I_RD1:   begin bus_re = 1'b1; bus_addr = ADDR_W'(1); end
            S_I_RST1:  bus_we = 1'b1;
            default:   ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state       <= S_IDLE;
            prog_phase  <= 1'b0;
            fail_q      <= 1'b0;
            tmo_q       <= 1'b0;
            id0_ok      <= 1'b0;
            err         <= 1'b0;
            err_tmo     <= 1'b0;
            err_addr    <= '0;
            probe_match <= 1'b0;
        end else begin
            state <= nxt;
            case (state)
                S_IDLE: begin
                    if (start_prog || start_probe) begin
                        err      <= 1'b0;
                        err_tmo  <= 1'b0;
                        err_addr <= '0;
                        fail_q   <= 1'b0;
                        tmo_q    <= 1'b0;
                    end
                    if (start_prog)       prog_phase  <= 1'b0;
                    else if (start_probe) probe_match <= 1'b0;
                end
                S_W_POLL: begin
                    if (st_ready)        fail_q <= st_fail;
                    else if (tm_expired) tmo_q  <= 1'b1;
                end
                S_W_RST: begin
                    if (fail_q || tmo_q) begin
                        err      <= 1'b1;
                        err_tmo  <= tmo_q;
                        err_addr <= cur;
                    end else if (!prog_phase && last_blk) begin
                        prog_phase <= 1'b1;
                    end
                end
                S_I_RD0: id0_ok      <= (bus_rdata == exp_id0);
                S_I_RD1: probe_match <= id0_ok && (bus_rdata == exp_id1);
                default: ;
            endcase
        end
    end

    assign src_addr = cur;
    assign busy     = (state != S_IDLE) && (state != S_FIN);
    assign done     = (state == S_FIN);
endmodule

// File: rtl/fseq_checker.sv
module fseq_checker #(
    parameter int ADDR_W = 6
) (
    input logic              clk,
    input logic              rst,
    input logic              start_prog,
    input logic              start_probe,
    input logic              busy,
    input logic              done,
    input logic              err,
    input logic [ADDR_W-1:0] err_addr,
    input logic              bus_we,
    input logic              bus_re
);
    p_one_strobe_r11: assert property (@(posedge clk) disable iff (rst)
        !(bus_we && bus_re));

    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (!bus_we && !bus_re));

    p_done_pulse_r9: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    p_done_after_busy_r9: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(busy));

    p_busy_ends_in_done_r9: assert property (@(posedge clk) disable iff (rst)
        busy |=> (busy || done));

    p_err_with_done_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(err) |-> done);

    p_err_held_r6: assert property (@(posedge clk) disable iff (rst)
        (!busy && !done && !start_prog && !start_probe) |=> ($stable(err) && $stable(err_addr)));
endmodule

bind flash_erase_prog_seq fseq_checker #(.ADDR_W(ADDR_W)) i_chk (
    .clk(clk), .rst(rst), .start_prog(start_prog), .start_probe(start_probe),
    .busy(busy), .done(done), .err(err), .err_addr(err_addr),
    .bus_we(bus_we), .bus_re(bus_re)
);

// File: tb/test_flash_erase_prog_seq.sv
module test_flash_erase_prog_seq;
    localparam int CLK_PERIOD = 10;
    localparam int AW   = 6;
    localparam int NB   = 1 << AW;
    localparam int BSZ  = 16;
    localparam int NBLK = NB / BSZ;
    localparam int PMAX = 16;
    localparam logic [7:0] ID0 = 8'hB7;
    localparam logic [7:0] ID1 = 8'h4C;

    logic clk = 0, rst = 1;
    logic start_prog = 0, start_probe = 0;
    logic [7:0] exp_id0 = ID0, exp_id1 = ID1;
    logic [AW-1:0] src_addr, bus_addr, err_addr;
    logic [7:0] src_data, bus_wdata, bus_rdata;
    logic bus_we, bus_re, busy, done, err, err_tmo, probe_match;

    int nchecks = 0, nfail = 0, cycles = 0;

    // device model configuration (driven by the stimulus process only)
    int seed = 0, lat = 0, inj_addr = -1;
    bit inj_erase = 0, stuck = 0, preload = 0, mon_clr = 0;

    // device model state
    logic [7:0] mem [NB];
    int dmode = 0;       // 0 array, 1 identifier, 2 status
    int pend  = 0;       // 1 expect program data, 2 expect erase confirm
    int bcnt  = 0;
    logic [7:0] serr = 8'h00;

    // monitor counters
    int n_clr, n_era, n_conf, n_stat, n_ffw, n_pcmd, n_data, n_id, n_done;
    int next_blk, next_byte, order_bad, prog_early, id_rd, rd_cnt, rd_min, rd_max;
    bit wait_open;

    function automatic logic [7:0] src_fn(int a, int sd);
        return 8'((a * 29) + (sd * 7) + (a >> 2));
    endfunction

    assign src_data = src_fn(int'(src_addr), seed);
    assign bus_rdata = (dmode == 2) ? ({(bcnt == 0 && !stuck), 7'b0} | serr) :
                       (dmode == 1) ? ((bus_addr == 0) ? ID0 : (bus_addr == 1) ? ID1 : 8'h00) :
                       mem[bus_addr];

    flash_erase_prog_seq #(.ADDR_W(AW), .BLK_W(4), .POLL_MAX(PMAX)) i_flash_erase_prog_seq (
        .clk(clk), .rst(rst), .start_prog(start_prog), .start_probe(start_probe),
        .exp_id0(exp_id0), .exp_id1(exp_id1), .src_addr(src_addr), .src_data(src_data),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_we(bus_we), .bus_re(bus_re),
        .bus_rdata(bus_rdata), .busy(busy), .done(done), .err(err), .err_tmo(err_tmo),
        .err_addr(err_addr), .probe_match(probe_match)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    // device model and bus monitor
    always @(posedge clk) begin
        if (bcnt > 0) bcnt <= bcnt - 1;
        if (preload) for (int i = 0; i < NB; i++) mem[i] <= 8'((i * 53) + 11);
        if (mon_clr) begin
            n_clr = 0; n_era = 0; n_conf = 0; n_stat = 0; n_ffw = 0; n_pcmd = 0;
            n_data = 0; n_id = 0; n_done = 0; next_blk = 0; next_byte = 0;
            order_bad = 0; prog_early = 0; id_rd = 0; rd_cnt = 0;
            rd_min = 1000; rd_max = 0; wait_open = 0;
        end else begin
            if (done) n_done++;
            if (bus_re) begin
                if (wait_open) rd_cnt++;
                if (dmode == 1) begin
                    if (int'(bus_addr) != id_rd) order_bad++;
                    id_rd++;
                end
            end
            if (bus_we) begin
                if (pend == 1) begin
                    n_data++;
                    if (int'(bus_addr) != next_byte || bus_wdata != src_fn(int'(bus_addr), seed))
                        order_bad++;
                    next_byte++;
                    mem[bus_addr] <= mem[bus_addr] & bus_wdata;
                    pend <= 0; dmode <= 2; bcnt <= lat;
                    if (!inj_erase && int'(bus_addr) == inj_addr) serr <= serr | 8'h10;
                end else if (pend == 2) begin
                    pend <= 0;
                    if (bus_wdata == 8'hD0) begin
                        n_conf++;
                        for (int i = 0; i < BSZ; i++) mem[(int'(bus_addr) & ~(BSZ - 1)) + i] <= 8'hFF;
                        dmode <= 2; bcnt <= lat;
                        if (inj_erase && int'(bus_addr) == inj_addr) serr <= serr | 8'h20;
                    end
                end else begin
                    case (bus_wdata)
                        8'hFF: begin
                            dmode <= 0;
                            if (wait_open) begin
                                n_ffw++;
                                if (bus_addr != 0) order_bad++;
                                if (rd_cnt < rd_min) rd_min = rd_cnt;
                                if (rd_cnt > rd_max) rd_max = rd_cnt;
                                wait_open = 0;
                            end
                        end
                        8'h90: begin dmode <= 1; n_id++; end
                        8'h70: begin
                            dmode <= 2; n_stat++; wait_open = 1; rd_cnt = 0;
                            if (bus_addr != 0) order_bad++;
                        end
                        8'h50: begin
                            serr <= 8'h00; n_clr++;
                            if (int'(bus_addr) != next_blk * BSZ) order_bad++;
                        end
                        8'h40: begin
                            pend <= 1; n_pcmd++;
                            if (n_conf < NBLK || int'(bus_addr) != next_byte) prog_early++;
                        end
                        8'h20: begin
                            pend <= 2; n_era++;
                            if (int'(bus_addr) != next_blk * BSZ) order_bad++;
                            next_blk++;
                        end
                        default: order_bad++;
                    endcase
                end
            end
        end
    end

    task automatic check(bit ok, string req, int act, int exp);
        nchecks++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wait_done();
        while (!done) @(negedge clk);
    endtask

    task automatic run_prog(int sd, int lt, int ia, bit ie, bit stk, bit with_probe);
        @(negedge clk);
        seed = sd; lat = lt; inj_addr = ia; inj_erase = ie; stuck = stk;
        preload = 1; mon_clr = 1;
        @(negedge clk);
        preload = 0; mon_clr = 0; start_prog = 1; start_probe = with_probe;
        @(negedge clk);
        start_prog = 0; start_probe = 0;
        wait_done();
    endtask

    task automatic run_probe(logic [7:0] e0, logic [7:0] e1);
        @(negedge clk);
        exp_id0 = e0; exp_id1 = e1; mon_clr = 1;
        @(negedge clk);
        mon_clr = 0; start_probe = 1;
        @(negedge clk);
        start_probe = 0;
        wait_done();
    endtask

    function automatic int mem_mismatch(int sd);
        int m = 0;
        for (int i = 0; i < NB; i++) if (mem[i] !== src_fn(i, sd)) m++;
        return m;
    endfunction

    // watchdog
    initial begin
        while (cycles < 150000) begin
            @(posedge clk);
            cycles++;
        end
        nchecks++; nfail++;
        $display("FAIL watchdog: actual %0d expected %0d", cycles, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", nchecks, nfail);
        $finish;
    end

    initial begin
        mon_clr = 1;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        mon_clr = 0;
        // R1: reset state
        check(!busy && !done && !err && !err_tmo, "R1", {busy, done, err, err_tmo}, 0);
        check(!bus_we && !bus_re, "R1", {bus_we, bus_re}, 0);

        // sweep of device latency and source patterns
        for (int lt = 0; lt < 5; lt++) begin
            int sd = lt * 37 + 5;
            run_prog(sd, lt, -1, 0, 0, 0);
            check(!err && !err_tmo, "R6", {err, err_tmo}, 0);
            check(n_era == NBLK && n_clr == NBLK && n_conf == NBLK, "R2", n_era, NBLK);
            check(order_bad == 0, "R2", order_bad, 0);
            check(n_stat == NBLK + NB && n_ffw == NBLK + NB, "R3", n_ffw, NBLK + NB);
            check(rd_min == (lt > 0 ? lt : 1) && rd_max == (lt > 0 ? lt : 1), "R3", rd_max, (lt > 0 ? lt : 1));
            check(prog_early == 0, "R4", prog_early, 0);
            check(n_pcmd == NB && n_data == NB, "R5", n_data, NB);
            check(mem_mismatch(sd) == 0, "R5", mem_mismatch(sd), 0);
            @(negedge clk);
            check(!done && !busy, "R9", {done, busy}, 0);
            check(n_done == 1, "R9", n_done, 1);
        end

        // R6: program failure at byte 37
        run_prog(11, 2, 37, 0, 0, 0);
        check(err && !err_tmo && err_addr == 37, "R6", {err, err_tmo, err_addr}, {2'b10, 6'd37});
        check(next_byte == 38 && n_ffw == n_stat, "R6", next_byte, 38);
        check(mem[38] == 8'hFF, "R6", mem[38], 8'hFF);
        repeat (4) @(negedge clk);
        check(err && err_addr == 37, "R6", err_addr, 37);

        // R6: erase failure at block base 32
        run_prog(12, 1, 32, 1, 0, 0);
        check(err && !err_tmo && err_addr == 32, "R6", err_addr, 32);
        check(n_era == 3 && n_pcmd == 0 && n_ffw == n_stat, "R6", n_era, 3);

        // R7: device never ready
        run_prog(13, 1, -1, 0, 1, 0);
        check(err && err_tmo && err_addr == 0, "R7", {err, err_tmo}, 3);
        check(rd_max == PMAX && n_ffw == 1, "R7", rd_max, PMAX);
        @(negedge clk);
        stuck = 0;

        // R8: identifier probe
        run_probe(ID0, ID1);
        check(probe_match && !err, "R8", probe_match, 1);
        check(n_id == 1 && id_rd == 2 && order_bad == 0, "R8", id_rd, 2);
        @(negedge clk);
        check(dmode == 0, "R8", dmode, 0);
        run_probe(ID0 ^ 8'h01, ID1);
        check(!probe_match, "R8", probe_match, 0);
        run_probe(ID0, ID1 ^ 8'h80);
        check(!probe_match, "R8", probe_match, 0);

        // R10: both requests in the same idle cycle
        run_prog(21, 1, -1, 0, 0, 1);
        check(n_id == 0 && n_data == NB && !err, "R10", n_id, 0);
        check(mem_mismatch(21) == 0, "R10", mem_mismatch(21), 0);

        // R10: probe request while busy
        @(negedge clk);
        seed = 22; lat = 2; inj_addr = -1; preload = 1; mon_clr = 1;
        @(negedge clk);
        preload = 0; mon_clr = 0; start_prog = 1;
        @(negedge clk);
        start_prog = 0;
        repeat (50) @(negedge clk);
        start_probe = 1;
        @(negedge clk);
        start_probe = 0;
        wait_done();
        repeat (4) @(negedge clk);
        check(!busy && n_done == 1 && n_id == 0, "R10", n_done, 1);
        check(mem_mismatch(22) == 0, "R10", mem_mismatch(22), 0);

        $display("End of test - %0d assertions evaluated, %0d failures", nchecks, nfail);
        $finish;
    end
endmodule